// File: doc/BRIEF.md
# Walk-Locking Memory Bus Arbiter

This block shares one memory bus among several harts. Each hart has two requesters: its CPU port for ordinary memory cycles and its MMU port for page-table fetches. The arbiter picks at most one requester per cycle and presents the choice as a registered one-hot grant vector. Its rules are built to give a hart that is trying to start execution a guaranteed path through a page walk and the accesses that follow, even when other harts keep rewriting page tables.

A page-table fetch beats any CPU access. When an MMU asks for the bus and marks the request as the start of a walk, that MMU owns the bus until it signals the end of the walk. No other port is granted during that time. The hart that finished the walk then gets a short follow-on window. First it gets one memory cycle. Next it gets preference for one more walk or table fetch. Last it gets one more memory cycle. After that the round-robin pointer moves past it. If the favoured hart has nothing pending at any point in the window, the window ends at once and normal arbitration resumes from the hart after it.

Top module: `mmu_prio_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant` is all zeros.
- R2: `grant` has at most one bit set. Bit h is the CPU port of hart h and bit N+h is the MMU port of hart h. A bit can be set only if that port's request was high in the previous cycle, because the grant is registered.
- R3: Outside any lock or window, if any MMU request is pending, an MMU port is granted and no CPU port is.
- R4: An MMU grant decided while `walk_start` of that hart is high locks the bus to that MMU. In each later decision cycle, only that MMU may be granted, or nothing. The lock ends in the decision cycle where that hart's `walk_done` is high.
- R5: In the cycle right after a walk ends, the same hart is favoured. Its CPU request is preferred, and its MMU request is taken if it has no CPU request.
- R6: After that first cycle, the hart is favoured for one more MMU access. If that access starts a walk, the window continues once the walk ends. The hart then gets one more memory cycle, with its MMU preferred. After this the round-robin pointer moves to the next hart. If the hart makes a CPU access in place of the MMU access, the window ends with that access.
- R7: If the favoured hart has no request at all in a window cycle, the window ends in that same cycle. Arbitration then starts from the hart after it.
- R8: Ties in normal arbitration go to the first requesting hart counting upward from the pointer, with wrap-around. MMU ports are searched before CPU ports. After every normal grant, the pointer moves to the hart after the one granted.
- R9: While the bus is locked, `walk_start` from any hart and `walk_done` from any hart other than the owner have no effect. `walk_start` without a matching `mmu_req` does not start a lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | N | CPU-port request per hart |
| mmu_req | input | N | MMU-port (page-table fetch) request per hart |
| walk_start | input | N | Qualifies that hart's MMU request as the first fetch of a walk |
| walk_done | input | N | The hart's walk has finished |
| grant | output | 2N | Registered one-hot grant: bits [N-1:0] CPU ports, [2N-1:N] MMU ports |

## Verification
The bench targets several corner cases, each with a known failure symptom. A CPU write or another MMU's fetch arriving during a locked walk would show up as a foreign grant before `walk_done`. A `walk_done` from the wrong hart that ends the lock early would let other harts in too soon. The follow-on window is checked in three ways: a missing window rotates away from the translating hart right after its walk, a window that is never forfeited stalls the bus on an idle hart, and a pointer moved to the wrong hart after the window breaks rotation. Long random traffic with frequent walk starts and stray completions is then compared cycle by cycle against a behavioural model of the rules.

// File: rtl/mmu_prio_arb_pkg.sv
// Shared types for the walk-locking arbiter.
package mmu_prio_arb_pkg;
    // Follow-on window stages for the hart that just completed a walk.
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,  // no favoured hart
        WIN_CYC1  = 2'd1,  // first memory cycle after the walk
        WIN_WALK2 = 2'd2,  // one further translation (walk or fetch)
        WIN_CYC2  = 2'd3   // one further memory cycle
    } win_stage_e;
endpackage

// File: rtl/mpa_rr_pick.sv
// Round-robin picker: finds the first set bit of req at or after index base,
// wrapping around. Assumes base < N. Purely combinational.
module mpa_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          vld,
    output logic [IW-1:0] idx
);
    // Scan from base upward with wrap; first hit wins.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int pos;
            pos = int'(base) + k;
            if (pos >= N) pos = pos - N;
            if (!vld && req[pos]) begin
                vld = 1'b1;
                idx = IW'(pos);
            end
        end
    end
endmodule

// File: rtl/mpa_ctrl.sv
// Arbitration controller: holds the walk lock, the follow-on window and the
// round-robin pointer, and decides the next grant from current requests.
// Assumes the round-robin picks are computed from the base it drives.
module mpa_ctrl
    import mmu_prio_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   cpu_req,
    input  logic [N-1:0]   mmu_req,
    input  logic [N-1:0]   walk_start,
    input  logic [N-1:0]   walk_done,
    input  logic           mmu_vld,
    input  logic [IW-1:0]  mmu_idx,
    input  logic           cpu_vld,
    input  logic [IW-1:0]  cpu_idx,
    output logic [IW-1:0]  base,
    output logic [2*N-1:0] gnt_nxt
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic          locked_q, locked_n;
    logic          chain_q, chain_n;
    logic [IW-1:0] owner_q, owner_n;
    logic [IW-1:0] ptr_q, ptr_n;
    win_stage_e    stage_q, stage_n;
    logic          own_cpu, own_mmu, own_ws, forfeit;
    logic [IW-1:0] owner_inc;

    // Wrap-around increment of an index.
    function automatic logic [IW-1:0] inc(input logic [IW-1:0] x);
        return (x == LAST) ? '0 : x + 1'b1;
    endfunction

    // Favoured-hart request view and window forfeit detection.
    always_comb begin
        own_cpu   = cpu_req[owner_q];
        own_mmu   = mmu_req[owner_q];
        own_ws    = walk_start[owner_q];
        owner_inc = inc(owner_q);
        forfeit   = !locked_q && (stage_q != WIN_IDLE) && !own_cpu && !own_mmu;
        base      = forfeit ? owner_inc : ptr_q;
    end

    // Next-grant decision and next-state computation.
    always_comb begin
        gnt_nxt  = '0;
        locked_n = locked_q;
        chain_n  = chain_q;
        owner_n  = owner_q;
        ptr_n    = ptr_q;
        stage_n  = stage_q;
        if (locked_q) begin
            if (own_mmu) gnt_nxt[N + int'(owner_q)] = 1'b1;
            if (walk_done[owner_q]) begin
                locked_n = 1'b0;
                stage_n  = chain_q ? WIN_CYC2 : WIN_CYC1;
                chain_n  = 1'b0;
            end
        end else if (stage_q != WIN_IDLE && !forfeit) begin
            unique case (stage_q)
                WIN_CYC1: begin
                    stage_n = WIN_WALK2;
                    if (own_cpu) begin
                        gnt_nxt[int'(owner_q)] = 1'b1;
                    end else begin
                        gnt_nxt[N + int'(owner_q)] = 1'b1;
                        if (own_ws) begin
                            locked_n = 1'b1;
                            chain_n  = 1'b0;
                            stage_n  = WIN_IDLE;
                        end
                    end
                end
                WIN_WALK2: begin
                    if (own_mmu) begin
                        gnt_nxt[N + int'(owner_q)] = 1'b1;
                        if (own_ws) begin
                            locked_n = 1'b1;
                            chain_n  = 1'b1;
                            stage_n  = WIN_IDLE;
                        end else begin
                            stage_n = WIN_CYC2;
                        end
                    end else begin
                        gnt_nxt[int'(owner_q)] = 1'b1;
                        stage_n = WIN_IDLE;
                        ptr_n   = owner_inc;
                    end
                end
                default: begin
                    stage_n = WIN_IDLE;
                    ptr_n   = owner_inc;
                    if (own_mmu) begin
                        gnt_nxt[N + int'(owner_q)] = 1'b1;
                        if (own_ws) begin
                            locked_n = 1'b1;
                            chain_n  = 1'b0;
                        end
                    end else begin
                        gnt_nxt[int'(owner_q)] = 1'b1;
                    end
                end
            endcase
        end else begin
            stage_n = WIN_IDLE;
            ptr_n   = base;
            if (mmu_vld) begin
                gnt_nxt[N + int'(mmu_idx)] = 1'b1;
                ptr_n = inc(mmu_idx);
                if (walk_start[mmu_idx]) begin
                    locked_n = 1'b1;
                    chain_n  = 1'b0;
                    owner_n  = mmu_idx;
                end
            end else if (cpu_vld) begin
                gnt_nxt[int'(cpu_idx)] = 1'b1;
                ptr_n = inc(cpu_idx);
            end
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            chain_q  <= 1'b0;
            owner_q  <= '0;
            ptr_q    <= '0;
            stage_q  <= WIN_IDLE;
        end else begin
            locked_q <= locked_n;
            chain_q  <= chain_n;
            owner_q  <= owner_n;
            ptr_q    <= ptr_n;
            stage_q  <= stage_n;
        end
    end
endmodule

// File: rtl/mmu_prio_arb.sv
// Top of the walk-locking memory bus arbiter: two round-robin pickers (MMU
// and CPU ports), the controller, and the registered one-hot grant.
// Assumes requesters hold requests until granted; grant follows by one cycle.
module mmu_prio_arb #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   cpu_req,
    input  logic [N-1:0]   mmu_req,
    input  logic [N-1:0]   walk_start,
    input  logic [N-1:0]   walk_done,
    output logic [2*N-1:0] grant
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0]  base, mmu_idx, cpu_idx;
    logic           mmu_vld, cpu_vld;
    logic [2*N-1:0] gnt_nxt;

    mpa_rr_pick #(.N(N), .IW(IW)) u_pick_mmu (
        .req(mmu_req), .base(base), .vld(mmu_vld), .idx(mmu_idx)
    );

    mpa_rr_pick #(.N(N), .IW(IW)) u_pick_cpu (
        .req(cpu_req), .base(base), .vld(cpu_vld), .idx(cpu_idx)
    );

    mpa_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .mmu_req(mmu_req),
        .walk_start(walk_start), .walk_done(walk_done),
        .mmu_vld(mmu_vld), .mmu_idx(mmu_idx),
        .cpu_vld(cpu_vld), .cpu_idx(cpu_idx),
        .base(base), .gnt_nxt(gnt_nxt)
    );

    // Output register holding the granted port for the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) grant <= '0;
        else        grant <= gnt_nxt;
    end
endmodule

// File: rtl/mmu_prio_arb_chk.sv
// Checker for the arbiter. It rebuilds the walk lock from the port view only:
// a walk starts when an MMU grant appears for a request that carried
// walk_start, and it ends with that hart's walk_done.
module mmu_prio_arb_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   cpu_req,
    input logic [N-1:0]   mmu_req,
    input logic [N-1:0]   walk_start,
    input logic [N-1:0]   walk_done,
    input logic [2*N-1:0] grant
);
    logic [N-1:0] ws_q, own_q, own_c;
    logic         lk_hold, lk_prev, start_c, lk_c;

    // Detect a lock start from the visible grant and the qualifier it carried.
    always_comb begin
        start_c = 1'b0;
        own_c   = own_q;
        if (!lk_hold && !lk_prev) begin
            for (int i = 0; i < N; i++) begin
                if (grant[N + i] && ws_q[i]) begin
                    start_c = 1'b1;
                    own_c   = '0;
                    own_c[i] = 1'b1;
                end
            end
        end
        lk_c = lk_hold | start_c;
    end

    // Track qualifier history and lock state across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q    <= '0;
            own_q   <= '0;
            lk_hold <= 1'b0;
            lk_prev <= 1'b0;
        end else begin
            ws_q    <= walk_start;
            own_q   <= own_c;
            lk_prev <= lk_c;
            lk_hold <= lk_c && ((walk_done & own_c) == '0);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> grant == '0); // R1
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R2
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((grant & ~$past({mmu_req, cpu_req})) == '0)); // R2
    AST_WALK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_c |=> ((grant & ~{$past(own_c), {N{1'b0}}}) == '0)); // R4
    AST_NO_CPU_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_c |=> (grant[N-1:0] == '0)); // R4
endmodule

bind mmu_prio_arb mmu_prio_arb_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .mmu_req(mmu_req),
    .walk_start(walk_start), .walk_done(walk_done), .grant(grant)
);

// File: tb/mmu_prio_arb_bench.sv
// Bench: behavioural reference model stepped once per cycle and compared
// against the grant on every clock, plus directed corner-case phases.
module mmu_prio_arb_bench;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   cpu_req = '0, mmu_req = '0, walk_start = '0, walk_done = '0;
    logic [2*N-1:0] grant;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R1";

    // Reference model state (integers).
    int m_lk = 0, m_own = 0, m_stage = 0, m_chain = 0, m_ptr = 0;
    logic [2*N-1:0] exp_g = '0;

    always #10 clk = ~clk;

    mmu_prio_arb #(.N(N)) u_mmu_prio_arb (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .mmu_req(mmu_req),
        .walk_start(walk_start), .walk_done(walk_done), .grant(grant)
    );

    task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: grant=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One model step: expected grant for the next cycle from current inputs.
    task automatic model_step();
        logic [2*N-1:0] g;
        int h, b, pick;
        g = '0;
        h = m_own;
        if (m_lk != 0) begin
            if (mmu_req[h]) g[N + h] = 1'b1;
            if (walk_done[h]) begin
                m_lk = 0;
                m_stage = (m_chain != 0) ? 3 : 1;
                m_chain = 0;
            end
        end else if (m_stage != 0 && (cpu_req[h] || mmu_req[h])) begin
            if (m_stage == 1) begin
                m_stage = 2;
                if (cpu_req[h]) g[h] = 1'b1;
                else begin
                    g[N + h] = 1'b1;
                    if (walk_start[h]) begin m_lk = 1; m_chain = 0; m_stage = 0; end
                end
            end else if (m_stage == 2) begin
                if (mmu_req[h]) begin
                    g[N + h] = 1'b1;
                    if (walk_start[h]) begin m_lk = 1; m_chain = 1; m_stage = 0; end
                    else m_stage = 3;
                end else begin
                    g[h] = 1'b1;
                    m_stage = 0;
                    m_ptr = (h + 1) % N;
                end
            end else begin
                m_stage = 0;
                m_ptr = (h + 1) % N;
                if (mmu_req[h]) begin
                    g[N + h] = 1'b1;
                    if (walk_start[h]) begin m_lk = 1; m_chain = 0; end
                end else g[h] = 1'b1;
            end
        end else begin
            b = (m_stage != 0) ? (h + 1) % N : m_ptr;
            m_stage = 0;
            m_ptr = b;
            pick = -1;
            for (int k = 0; k < N; k++)
                if (pick < 0 && mmu_req[(b + k) % N]) pick = (b + k) % N;
            if (pick >= 0) begin
                g[N + pick] = 1'b1;
                m_ptr = (pick + 1) % N;
                if (walk_start[pick]) begin m_lk = 1; m_chain = 0; m_own = pick; end
            end else begin
                for (int k = 0; k < N; k++)
                    if (pick < 0 && cpu_req[(b + k) % N]) pick = (b + k) % N;
                if (pick >= 0) begin
                    g[pick] = 1'b1;
                    m_ptr = (pick + 1) % N;
                end
            end
        end
        exp_g = g;
    endtask

    // Drive one cycle: compare current grant, apply inputs, advance model.
    task automatic cyc(input string req, input logic [N-1:0] c, input logic [N-1:0] m,
                       input logic [N-1:0] ws, input logic [N-1:0] wd);
        @(negedge clk);
        check(req, grant, exp_g);
        if (!$onehot0(grant)) check({req, " onehot"}, grant, '0);
        tag = req;
        cpu_req = c; mmu_req = m; walk_start = ws; walk_done = wd;
        model_step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: grant=%b expected=%b", grant, exp_g);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1: reset holds grant low even with requests present.
        cpu_req = '1; mmu_req = '1;
        repeat (3) begin @(negedge clk); check("R1", grant, '0); end
        cpu_req = '0; mmu_req = '0;
        @(negedge clk); rst_n = 1'b1; exp_g = '0;
        cyc("R1", '0, '0, '0, '0);
        // R3: MMU beats CPU; pointer 0 so MMU 2 picked.
        cyc("R3", 4'b1111, 4'b0100, '0, '0);
        // R8: tie between MMU 0 and 3; pointer now 3, so MMU 3; then 0.
        cyc("R8", '0, 4'b1001, '0, '0);
        cyc("R8", '0, 4'b0001, '0, '0);
        cyc("R8", 4'b1010, '0, '0, '0);
        // R4: MMU 1 starts a walk; others request heavily.
        cyc("R4", '0, 4'b0010, 4'b0010, '0);
        cyc("R4", 4'b1111, 4'b1111, '0, '0);
        cyc("R4", 4'b1111, 4'b1101, '0, '0);
        // R9: stray done from hart 3 and start from hart 0 while locked.
        cyc("R9", 4'b1111, 4'b1111, 4'b0001, 4'b1000);
        cyc("R9", 4'b1111, 4'b1111, '0, '0);
        cyc("R4", 4'b1111, 4'b1111, '0, 4'b0010);
        // R5: first cycle after the walk goes to hart 1 (CPU first).
        cyc("R5", 4'b1111, 4'b1111, '0, '0);
        // R6: hart 1 walks again, finishes, gets one more cycle, then rotate.
        cyc("R6", 4'b1111, 4'b1111, 4'b0010, '0);
        cyc("R6", 4'b1111, 4'b0010, '0, 4'b0010);
        cyc("R6", 4'b1111, 4'b1101, '0, '0);
        cyc("R6", 4'b1111, '0, '0, '0);
        cyc("R6", 4'b1111, '0, '0, '0);
        // R7: hart 0 walks, then goes idle; window forfeited.
        cyc("R7", '0, 4'b0001, 4'b0001, 4'b0001);
        cyc("R7", '0, 4'b0001, '0, 4'b0001);
        cyc("R7", 4'b0110, '0, '0, '0);
        cyc("R7", 4'b0110, '0, '0, '0);
        // R9: walk_start without mmu_req creates no lock.
        cyc("R9", 4'b0100, '0, 4'b0100, '0);
        cyc("R9", 4'b0101, '0, '0, '0);
        cyc("R9", '0, '0, '0, '0);
        // R2: long random traffic with walks, compared every clock.
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] c, m, ws, wd;
            c  = N'($urandom);
            m  = N'($urandom) & N'($urandom);
            ws = m & N'($urandom);
            wd = N'($urandom) & N'($urandom);
            cyc("R2", c, m, ws, wd);
        end
        cyc("R2", '0, '0, '0, '0);
        @(negedge clk);
        check("R2", grant, exp_g);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule